// File: doc/BRIEF.md
# Interrupt, Test and Reset Input Conditioner

This block sits between a processor core and four of its asynchronous control pins: a maskable interrupt request, a non-maskable interrupt, an active-low test input and a processor reset request. Each pin is brought into the clock domain through a synchronizer chain. Only the synchronized copies are used for sampling, edge detection or counting.

The core tells the block when it is in the last clock of an instruction, what its interrupt-enable flag is, whether a WAIT instruction is running, and when it has accepted a pending interrupt. In return the block offers four things. The first is a registered pending-interrupt indication with an NMI flag and a type number. The second is a stall request for the WAIT instruction. The third is a qualified core reset. The fourth is a one-cycle restart strobe that carries the fixed restart address.

Top module: `ctrl_in_cond`

## Requirements
- R1: Every asynchronous pin (`intr_i`, `nmi_i`, `test_n_i`, `reset_i`) passes through two flops. A change on a pin first affects any output two rising edges after it is set up.
- R2: In a cycle with `insn_end_i` high, no interrupt pending and no NMI latched, the block raises `irq_pending_o` on the next edge if the synchronized `intr_i` is high and `ie_flag_i` is high. It then shows `irq_nmi_o`=0 and `irq_type_o`=0.
- R3: While `ie_flag_i` is low, a high `intr_i` never makes an interrupt pending.
- R4: `intr_i` is sampled only in cycles with `insn_end_i` high. A request that comes and goes between two boundaries is lost.
- R5: A rising edge of the synchronized `nmi_i` is latched. At the next boundary it becomes pending with `irq_nmi_o`=1 and `irq_type_o`=2, whatever the value of `ie_flag_i`.
- R6: `nmi_i` held high yields only one NMI. A new NMI needs a new low-to-high transition.
- R7: When an NMI is latched and a maskable request is valid at the same boundary, the NMI is taken first. The maskable request is taken at a later boundary.
- R8: A pending interrupt stays pending until `irq_ack_i`. The edge after `irq_ack_i` clears it. Acknowledging an NMI also clears the NMI latch.
- R9: `wait_stall_o` is high exactly when `wait_active_i` is high and the synchronized `test_n_i` is high.
- R10: `core_reset_o` rises after the synchronized `reset_i` has been high for 4 consecutive edges. It stays high until that synchronized level goes low. A pin held high for N>=4 cycles gives N-3 cycles of `core_reset_o`.
- R11: A `reset_i` pulse shorter than 4 cycles has no effect on `core_reset_o` or `restart_o`.
- R12: When a qualified reset is released, `restart_o` pulses for exactly one cycle, in the cycle `core_reset_o` falls. `restart_addr_o` is always 0xFFFF0.
- R13: While `core_reset_o` is high, any pending interrupt and any latched NMI are discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset of the block itself |
| intr_i | input | 1 | Asynchronous maskable interrupt request, level, active high |
| nmi_i | input | 1 | Asynchronous non-maskable interrupt, rising-edge sensitive |
| test_n_i | input | 1 | Asynchronous test input, low releases a WAIT |
| reset_i | input | 1 | Asynchronous processor reset request, active high |
| insn_end_i | input | 1 | Core is in the last clock of an instruction |
| ie_flag_i | input | 1 | Core interrupt-enable flag |
| wait_active_i | input | 1 | Core is executing a WAIT instruction |
| irq_ack_i | input | 1 | Core accepts the pending interrupt |
| irq_pending_o | output | 1 | An interrupt is pending for the core |
| irq_nmi_o | output | 1 | Pending interrupt is the non-maskable one |
| irq_type_o | output | 8 | 2 for NMI, 0 otherwise |
| wait_stall_o | output | 1 | Core must stay idle in WAIT |
| core_reset_o | output | 1 | Qualified reset to the core |
| restart_o | output | 1 | One-cycle strobe on reset release |
| restart_addr_o | output | 20 | Restart address, fixed 0xFFFF0 |

## Verification
The bound checker watches every cycle for several properties. A pending interrupt may appear only after a boundary cycle, and a maskable one only with the enable flag set. Pending holds until acknowledge and clears after it. The type follows the NMI flag, and the stall output never appears outside WAIT. The restart strobe is single-cycle and aligned with the fall of `core_reset_o`, and a qualified reset leaves nothing pending. Some behaviours need a stimulus history and only the bench scenarios can show them: the two-edge synchronizer latency, that a held NMI fires once, that a short request between boundaries is lost, NMI-over-maskable ordering, and the 4-cycle reset qualification with its N-3 length. The bench checks these through a behavioural model compared on every clock and through directed checks.

// File: rtl/ctrl_in_cond_pkg.sv
// Package: shared constants and types for the input conditioner.
// Assumes: one clock domain; bit positions below index the sync bundle.
package ctrl_in_cond_pkg;
    localparam int PIN_INTR = 0;
    localparam int PIN_NMI  = 1;
    localparam int PIN_TEST = 2;
    localparam int PIN_RST  = 3;
    localparam int PIN_CNT  = 4;

    localparam int TYPE_W   = 8;
    localparam int ADDR_W   = 20;
    localparam logic [TYPE_W-1:0] NMI_TYPE     = 8'd2;
    localparam logic [ADDR_W-1:0] RESTART_ADDR = 20'hFFFF0;

    typedef enum logic [1:0] {
        SRC_NONE = 2'd0,
        SRC_MASK = 2'd1,
        SRC_NMI  = 2'd2
    } irq_src_e;
endpackage

// File: rtl/cond_sync.sv
// Module: cond_sync
// Brings a bundle of asynchronous pins into the clock domain through a
// chain of STAGES flops per bit. Assumes each pin is a level that the
// downstream logic tolerates seeing STAGES edges late.
module cond_sync #(
    parameter int WIDTH  = 4,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);
    logic [STAGES-1:0][WIDTH-1:0] stage_q;

    // Shift the pin bundle through the synchronizer chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage_q <= '0;
        end else begin
            stage_q[0] <= async_i;
            for (int i = 1; i < STAGES; i++) begin
                stage_q[i] <= stage_q[i-1];
            end
        end
    end

    assign sync_o = stage_q[STAGES-1];
endmodule

// File: rtl/cond_irq.sv
// Module: cond_irq
// Latches rising edges of the synchronized NMI, samples the maskable
// request at instruction boundaries under the enable flag, arbitrates
// with NMI first and holds the winner until the core acknowledges.
// Assumes all inputs are synchronous; clr_i discards all interrupt state.
module cond_irq
    import ctrl_in_cond_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic clr_i,
    input  logic intr_s_i,
    input  logic nmi_s_i,
    input  logic ie_i,
    input  logic insn_end_i,
    input  logic ack_i,
    output logic pend_o,
    output logic pend_nmi_o
);
    logic     nmi_prev_q;
    logic     nmi_latch_q;
    logic     pend_q;
    logic     pend_nmi_q;
    logic     nmi_rise;
    logic     nmi_taken;
    irq_src_e pick;

    assign nmi_rise  = nmi_s_i & ~nmi_prev_q;
    assign nmi_taken = ack_i & pend_q & pend_nmi_q;

    // Remember the previous synchronized NMI level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) nmi_prev_q <= 1'b0;
        else        nmi_prev_q <= nmi_s_i;
    end

    // Hold a detected NMI edge until its acknowledge; a new edge wins.
    always_ff @(posedge clk) begin
        if (!rst_n || clr_i) nmi_latch_q <= 1'b0;
        else                 nmi_latch_q <= nmi_rise | (nmi_latch_q & ~nmi_taken);
    end

    // Choose the source to offer at a boundary, NMI before maskable.
    always_comb begin
        if (nmi_latch_q)           pick = SRC_NMI;
        else if (intr_s_i && ie_i) pick = SRC_MASK;
        else                       pick = SRC_NONE;
    end

    // Register the pending interrupt at a boundary and drop it on acknowledge.
    always_ff @(posedge clk) begin
        if (!rst_n || clr_i) begin
            pend_q     <= 1'b0;
            pend_nmi_q <= 1'b0;
        end else if (ack_i) begin
            pend_q     <= 1'b0;
            pend_nmi_q <= 1'b0;
        end else if (insn_end_i && !pend_q && pick != SRC_NONE) begin
            pend_q     <= 1'b1;
            pend_nmi_q <= (pick == SRC_NMI);
        end
    end

    assign pend_o     = pend_q;
    assign pend_nmi_o = pend_nmi_q;
endmodule

// File: rtl/cond_rst.sv
// Module: cond_rst
// Qualifies the synchronized reset request: it must stay high for
// MIN_CYCLES consecutive edges before the core reset is asserted, and
// its release produces a single restart strobe. Assumes rst_s_i is synchronous.
module cond_rst #(
    parameter int MIN_CYCLES = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rst_s_i,
    output logic qual_o,
    output logic restart_o
);
    localparam int CW = $clog2(MIN_CYCLES + 1);
    localparam logic [CW-1:0] CNT_MAX = CW'(MIN_CYCLES);

    logic [CW-1:0] cnt_q;
    logic          restart_q;
    logic          full;

    assign full = (cnt_q == CNT_MAX);

    // Count consecutive high cycles, saturating at the minimum width.
    always_ff @(posedge clk) begin
        if (!rst_n)        cnt_q <= '0;
        else if (!rst_s_i) cnt_q <= '0;
        else if (!full)    cnt_q <= cnt_q + 1'b1;
    end

    // Strobe once when a qualified reset is released.
    always_ff @(posedge clk) begin
        if (!rst_n) restart_q <= 1'b0;
        else        restart_q <= full & ~rst_s_i;
    end

    assign qual_o    = full;
    assign restart_o = restart_q;
endmodule

// File: rtl/ctrl_in_cond.sv
// Module: ctrl_in_cond (top)
// Conditions the processor's asynchronous interrupt, NMI, test and reset
// pins for the core. Assumes the core drives insn_end_i, ie_flag_i,
// wait_active_i and irq_ack_i synchronously to clk.
module ctrl_in_cond
    import ctrl_in_cond_pkg::*;
#(
    parameter int SYNC_STAGES    = 2,
    parameter int RST_MIN_CYCLES = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              intr_i,
    input  logic              nmi_i,
    input  logic              test_n_i,
    input  logic              reset_i,
    input  logic              insn_end_i,
    input  logic              ie_flag_i,
    input  logic              wait_active_i,
    input  logic              irq_ack_i,
    output logic              irq_pending_o,
    output logic              irq_nmi_o,
    output logic [TYPE_W-1:0] irq_type_o,
    output logic              wait_stall_o,
    output logic              core_reset_o,
    output logic              restart_o,
    output logic [ADDR_W-1:0] restart_addr_o
);
    logic [PIN_CNT-1:0] raw_pins;
    logic [PIN_CNT-1:0] sync_pins;
    logic               qual_rst;

    always_comb begin
        raw_pins           = '0;
        raw_pins[PIN_INTR] = intr_i;
        raw_pins[PIN_NMI]  = nmi_i;
        raw_pins[PIN_TEST] = test_n_i;
        raw_pins[PIN_RST]  = reset_i;
    end

    cond_sync #(
        .WIDTH  (PIN_CNT),
        .STAGES (SYNC_STAGES)
    ) sync_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (raw_pins),
        .sync_o  (sync_pins)
    );

    cond_rst #(
        .MIN_CYCLES (RST_MIN_CYCLES)
    ) rst_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .rst_s_i   (sync_pins[PIN_RST]),
        .qual_o    (qual_rst),
        .restart_o (restart_o)
    );

    cond_irq irq_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .clr_i      (qual_rst),
        .intr_s_i   (sync_pins[PIN_INTR]),
        .nmi_s_i    (sync_pins[PIN_NMI]),
        .ie_i       (ie_flag_i),
        .insn_end_i (insn_end_i),
        .ack_i      (irq_ack_i),
        .pend_o     (irq_pending_o),
        .pend_nmi_o (irq_nmi_o)
    );

    assign irq_type_o     = irq_nmi_o ? NMI_TYPE : '0;
    assign wait_stall_o   = wait_active_i & sync_pins[PIN_TEST];
    assign core_reset_o   = qual_rst;
    assign restart_addr_o = RESTART_ADDR;
endmodule

// File: rtl/ctrl_in_cond_chk.sv
// Module: ctrl_in_cond_chk
// Cycle-level properties on the conditioner's ports, bound to the top.
module ctrl_in_cond_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        insn_end_i,
    input logic        ie_flag_i,
    input logic        wait_active_i,
    input logic        irq_ack_i,
    input logic        irq_pending_o,
    input logic        irq_nmi_o,
    input logic [7:0]  irq_type_o,
    input logic        wait_stall_o,
    input logic        core_reset_o,
    input logic        restart_o
);
    // R2
    pend_at_boundary_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_pending_o) |-> $past(insn_end_i));

    // R3
    mask_needs_ie_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(irq_pending_o) && !irq_nmi_o) |-> $past(ie_flag_i));

    // R5
    nmi_type_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_pending_o && irq_nmi_o) |-> (irq_type_o == 8'd2));

    // R2
    mask_type_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_nmi_o |-> (irq_type_o == 8'd0));

    // R8
    pend_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_pending_o && !irq_ack_i && !core_reset_o) |=> irq_pending_o);

    // R8
    ack_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_ack_i |=> !irq_pending_o);

    // R9
    stall_in_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wait_stall_o |-> wait_active_i);

    // R12
    restart_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
        restart_o |-> ($past(core_reset_o) && !core_reset_o));

    // R12
    restart_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        restart_o |=> !restart_o);

    // R13
    reset_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        core_reset_o |=> !irq_pending_o);
endmodule

bind ctrl_in_cond ctrl_in_cond_chk chk_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .insn_end_i    (insn_end_i),
    .ie_flag_i     (ie_flag_i),
    .wait_active_i (wait_active_i),
    .irq_ack_i     (irq_ack_i),
    .irq_pending_o (irq_pending_o),
    .irq_nmi_o     (irq_nmi_o),
    .irq_type_o    (irq_type_o),
    .wait_stall_o  (wait_stall_o),
    .core_reset_o  (core_reset_o),
    .restart_o     (restart_o)
);

// File: tb/ctrl_in_cond_tb_top.sv
// Bench: behavioural reference model compared on every clock, plus
// directed checks per requirement.
module ctrl_in_cond_tb_top;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic intr_i = 0, nmi_i = 0, test_n_i = 0, reset_i = 0;
    logic insn_end_i = 0, ie_flag_i = 0, wait_active_i = 0, irq_ack_i = 0;
    logic        irq_pending_o, irq_nmi_o, wait_stall_o, core_reset_o, restart_o;
    logic [7:0]  irq_type_o;
    logic [19:0] restart_addr_o;

    always #10 clk = ~clk;

    ctrl_in_cond dut_i (
        .clk(clk), .rst_n(rst_n), .intr_i(intr_i), .nmi_i(nmi_i),
        .test_n_i(test_n_i), .reset_i(reset_i), .insn_end_i(insn_end_i),
        .ie_flag_i(ie_flag_i), .wait_active_i(wait_active_i), .irq_ack_i(irq_ack_i),
        .irq_pending_o(irq_pending_o), .irq_nmi_o(irq_nmi_o), .irq_type_o(irq_type_o),
        .wait_stall_o(wait_stall_o), .core_reset_o(core_reset_o),
        .restart_o(restart_o), .restart_addr_o(restart_addr_o)
    );

    int total = 0;
    int failed = 0;
    string cur_req = "R1";
    bit done = 0;

    // Reference model state
    bit qi[$], qn[$], qt[$], qr[$];
    bit m_prev, m_latch, m_pend, m_pnmi, m_restart;
    int m_cnt;
    int rst_hi_cycles, restart_cnt;

    initial begin
        qi = '{0, 0}; qn = '{0, 0}; qt = '{0, 0}; qr = '{0, 0};
    end

    always @(posedge clk) begin
        bit s_i, s_n, s_r, rise, qual, nl;
        if (!rst_n) begin
            qi = '{0, 0}; qn = '{0, 0}; qt = '{0, 0}; qr = '{0, 0};
            m_prev = 0; m_latch = 0; m_pend = 0; m_pnmi = 0; m_restart = 0; m_cnt = 0;
        end else begin
            s_i = qi[0]; s_n = qn[0]; s_r = qr[0];
            rise = s_n && !m_prev;
            m_prev = s_n;
            qual = (m_cnt == 4);
            if (qual) begin
                m_latch = 0; m_pend = 0; m_pnmi = 0;
            end else begin
                nl = rise || (m_latch && !(irq_ack_i && m_pend && m_pnmi));
                if (irq_ack_i) begin
                    m_pend = 0; m_pnmi = 0;
                end else if (insn_end_i && !m_pend) begin
                    if (m_latch) begin m_pend = 1; m_pnmi = 1; end
                    else if (s_i && ie_flag_i) begin m_pend = 1; m_pnmi = 0; end
                end
                m_latch = nl;
            end
            m_restart = qual && !s_r;
            m_cnt = s_r ? ((m_cnt < 4) ? m_cnt + 1 : 4) : 0;
            qi.push_back(intr_i); void'(qi.pop_front());
            qn.push_back(nmi_i);  void'(qn.pop_front());
            qt.push_back(test_n_i); void'(qt.pop_front());
            qr.push_back(reset_i); void'(qr.pop_front());
        end
    end

    task automatic chk(string req, string what, int act, int exp);
        total++;
        if (act != exp) begin
            failed++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // One clock: wait past the edge, compare against the model.
    task automatic tick();
        int exp_type;
        @(posedge clk);
        @(negedge clk);
        exp_type = m_pnmi ? 2 : 0;
        if (core_reset_o) rst_hi_cycles++;
        if (restart_o) restart_cnt++;
        if (rst_n) begin
            total++;
            if (irq_pending_o !== m_pend || irq_nmi_o !== m_pnmi ||
                int'(irq_type_o) != exp_type ||
                wait_stall_o !== (wait_active_i && qt[0]) ||
                core_reset_o !== (m_cnt == 4) || restart_o !== m_restart ||
                restart_addr_o !== 20'hFFFF0) begin
                failed++;
                $display("FAIL %s model: actual pend=%0b nmi=%0b type=%0d stall=%0b crst=%0b rs=%0b expected pend=%0b nmi=%0b type=%0d stall=%0b crst=%0b rs=%0b",
                         cur_req, irq_pending_o, irq_nmi_o, irq_type_o, wait_stall_o,
                         core_reset_o, restart_o, m_pend, m_pnmi, exp_type,
                         wait_active_i && qt[0], m_cnt == 4, m_restart);
            end
        end
    endtask

    task automatic ticks(int n);
        for (int i = 0; i < n; i++) tick();
    endtask

    task automatic boundary();
        insn_end_i = 1; tick(); insn_end_i = 0;
    endtask

    task automatic ack();
        irq_ack_i = 1; tick(); irq_ack_i = 0; tick();
    endtask

    task automatic finish_up();
        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", total - failed, total);
            $finish;
        end
    endtask

    initial begin
        #(20 * 100000);
        total++; failed++;
        $display("FAIL watchdog expired");
        finish_up();
    end

    initial begin
        ticks(3);
        rst_n = 1;
        tick();
        cur_req = "R1";
        chk("R1", "reset pending", irq_pending_o, 0);
        chk("R10", "reset core_reset", core_reset_o, 0);
        chk("R12", "restart addr", int'(restart_addr_o), 20'hFFFF0);

        // R1 / R9: two-edge latency on the test pin
        cur_req = "R9";
        wait_active_i = 1; test_n_i = 1;
        tick(); chk("R1", "stall after 1 edge", wait_stall_o, 0);
        tick(); chk("R1", "stall after 2 edges", wait_stall_o, 1);
        wait_active_i = 0; tick(); chk("R9", "stall outside wait", wait_stall_o, 0);
        wait_active_i = 1; test_n_i = 0; ticks(2);
        chk("R9", "stall with test low", wait_stall_o, 0);
        wait_active_i = 0;

        // R2: maskable taken at boundary
        cur_req = "R2";
        ie_flag_i = 1; intr_i = 1; ticks(3);
        chk("R4", "no pend before boundary", irq_pending_o, 0);
        boundary();
        chk("R2", "maskable pending", irq_pending_o, 1);
        chk("R2", "maskable type", irq_type_o, 0);
        cur_req = "R8";
        ticks(4); chk("R8", "pending held", irq_pending_o, 1);
        ack(); chk("R8", "cleared by ack", irq_pending_o, 0);
        intr_i = 0; ticks(3);

        // R3: enable flag cleared
        cur_req = "R3";
        ie_flag_i = 0; intr_i = 1; ticks(3); boundary();
        chk("R3", "masked request", irq_pending_o, 0);
        intr_i = 0; ticks(3);

        // R4: short request between boundaries
        cur_req = "R4";
        ie_flag_i = 1; intr_i = 1; ticks(3); intr_i = 0; ticks(4); boundary();
        chk("R4", "lost between boundaries", irq_pending_o, 0);

        // R5: one-cycle NMI pulse, enable flag cleared
        cur_req = "R5";
        ie_flag_i = 0; nmi_i = 1; tick(); nmi_i = 0; ticks(5); boundary();
        chk("R5", "nmi pending", irq_pending_o, 1);
        chk("R5", "nmi flag", irq_nmi_o, 1);
        chk("R5", "nmi type", irq_type_o, 2);
        ack(); boundary();
        chk("R8", "nmi latch cleared by ack", irq_pending_o, 0);

        // R6: NMI held high fires once
        cur_req = "R6";
        nmi_i = 1; ticks(4); boundary();
        chk("R6", "held nmi first", irq_pending_o, 1);
        ack(); ticks(2); boundary();
        chk("R6", "held nmi no repeat", irq_pending_o, 0);
        nmi_i = 0; ticks(3);

        // R7: NMI before maskable
        cur_req = "R7";
        ie_flag_i = 1; intr_i = 1; nmi_i = 1; tick(); nmi_i = 0; ticks(4); boundary();
        chk("R7", "nmi wins", irq_nmi_o, 1);
        ack(); boundary();
        chk("R7", "maskable next", irq_pending_o, 1);
        chk("R7", "maskable type after nmi", irq_nmi_o, 0);
        ack(); intr_i = 0; ie_flag_i = 0; ticks(3);

        // R11: short reset pulse
        cur_req = "R11";
        rst_hi_cycles = 0; restart_cnt = 0;
        reset_i = 1; ticks(3); reset_i = 0; ticks(6);
        chk("R11", "short reset core_reset cycles", rst_hi_cycles, 0);
        chk("R11", "short reset restart", restart_cnt, 0);

        // R10 / R12: six-cycle reset
        cur_req = "R10";
        rst_hi_cycles = 0; restart_cnt = 0;
        reset_i = 1; ticks(6); reset_i = 0; ticks(6);
        chk("R10", "core_reset cycles", rst_hi_cycles, 3);
        chk("R12", "restart pulses", restart_cnt, 1);

        // R10 boundary: exactly four cycles
        rst_hi_cycles = 0; restart_cnt = 0;
        reset_i = 1; ticks(4); reset_i = 0; ticks(6);
        chk("R10", "min reset cycles", rst_hi_cycles, 1);
        chk("R12", "min reset restart", restart_cnt, 1);

        // R13: reset discards pending and latched NMI
        cur_req = "R13";
        nmi_i = 1; tick(); nmi_i = 0; ticks(4); boundary();
        chk("R13", "pending before reset", irq_pending_o, 1);
        nmi_i = 1; tick(); nmi_i = 0; ticks(3);
        reset_i = 1; ticks(6); reset_i = 0; ticks(6);
        chk("R13", "pending cleared", irq_pending_o, 0);
        boundary();
        chk("R13", "latch cleared", irq_pending_o, 0);

        ticks(3);
        finish_up();
    end
endmodule